// File: doc/BRIEF.md
# Configuration Port Bridge

The bridge sits between a simple single-beat memory-mapped host bus and the narrow synchronous configuration port of a clock synthesizer. It holds a two-bit control register (overall enable and synthesizer reset release) and a clock-source select register. Both drive block outputs directly.

Software reaches the synthesizer's internal 16-bit registers through a command word. One host write to the command offset, with its launch bit set, starts a whole port transaction. The bridge then drives a single-cycle port enable with the address, the write data and the direction, and waits for the port's ready pulse. A busy flag in the status word does two jobs. While it is set, new commands are refused. When it clears, the low half of the status word holds valid read data.

The usual sequence is: poll status until busy is clear, write a command, then poll again. After a read command, the result is taken from status bits 15:0.

Top module: `cfgport_bridge`

## Requirements
- R1: After a synchronous reset, the port enable is 0, busy is 0, the captured read data is 0, both control outputs are 0 and the clock-source select is 0.
- R2: A host write to offset 0x40 sets `ctl_enable` from data bit 0 and `ctl_release` from data bit 1 on the next cycle. A read of 0x40 returns them in bits 0 and 1, with all other bits zero.
- R3: A host write to offset 0x44 loads the low SEL_W data bits into `src_sel`. A read of 0x44 returns the last value written, zero-extended.
- R4: A host write to offset 0x70 with bit 29 set while idle does three things on the next cycle. It raises busy, it drives `prt_en` high for exactly one cycle, and it presents data bits 16 up to 16+PADDR_W-1 on `prt_addr` and bits 15:0 on `prt_wdata`.
- R5: `prt_we` equals the inverse of command bit 28, where 1 means read. It is held from launch until the next launch.
- R6: Busy clears in the cycle after an edge at which `prt_rdy` is high while busy. `prt_rdy` while idle has no effect.
- R7: When a read transaction completes, `prt_rdata` is captured into the status read-data field at that edge. A write completion, or a stray ready while idle, leaves the field unchanged.
- R8: A command written while busy is ignored. It causes no port enable, no change of port address, data or direction, and no write to the synthesizer.
- R9: A write to 0x70 with bit 29 clear launches nothing.
- R10: A host read returns its data on `hst_rdata` one cycle after the request. Offset 0x74 reads as busy in bit 16, read data in bits 15:0, and zero elsewhere.
- R11: Reads of the command offset 0x70 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr_en | input | 1 | Host write strobe, one beat |
| hst_rd_en | input | 1 | Host read strobe, one beat |
| hst_addr | input | ADDR_W | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after the read strobe |
| prt_en | output | 1 | One-cycle transaction strobe to the synthesizer port |
| prt_we | output | 1 | Port direction, 1 = write |
| prt_addr | output | PADDR_W | Port register address |
| prt_wdata | output | 16 | Port write data |
| prt_rdy | input | 1 | Port completion pulse |
| prt_rdata | input | 16 | Port read data, valid with `prt_rdy` |
| ctl_enable | output | 1 | Overall enable control bit |
| ctl_release | output | 1 | Synthesizer reset release control bit |
| src_sel | output | SEL_W | Clock-source select |

## Verification
On every cycle, the bound assertions check the following:
- a port enable is a single-cycle pulse that only appears as busy rises;
- busy falls exactly on an accepted ready;
- the port address, data and direction stay frozen while a transaction is outstanding;
- the read-data field changes only at a completion;
- the control bits follow a write to their register.

Only the bench's scenarios can show the rest, because they need a port model with variable latency and host polling of the status word. These cover read data arriving from the port, a write completion leaving the read field alone, a refused command producing no write at the port, and the readback layout of each offset.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  // byte offsets of the host-visible registers
  localparam logic [31:0] OFS_CTRL = 32'h40;
  localparam logic [31:0] OFS_SEL  = 32'h44;
  localparam logic [31:0] OFS_CMD  = 32'h70;
  localparam logic [31:0] OFS_STAT = 32'h74;

  // field positions inside the command and status words
  localparam int CMD_GO_BIT    = 29;
  localparam int CMD_RD_BIT    = 28;
  localparam int CMD_ADDR_LSB  = 16;
  localparam int STAT_BUSY_BIT = 16;
  localparam int PDATA_W       = 16;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_SEL,
    RS_CMD,
    RS_STAT
  } regsel_e;

  function automatic regsel_e decode_ofs(input logic [31:0] ofs);
    case (ofs)
      OFS_CTRL: return RS_CTRL;
      OFS_SEL:  return RS_SEL;
      OFS_CMD:  return RS_CMD;
      OFS_STAT: return RS_STAT;
      default:  return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cfgb_ctrl_regs.sv
module cfgb_ctrl_regs #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_sel,
  input  logic [1:0]       ctrl_bits,
  input  logic [SEL_W-1:0] sel_bits,
  output logic             ctl_enable,
  output logic             ctl_release,
  output logic [SEL_W-1:0] src_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_enable  <= 1'b0;
      ctl_release <= 1'b0;
      src_sel     <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl_enable  <= ctrl_bits[0];
        ctl_release <= ctrl_bits[1];
      end
      if (wr_sel) src_sel <= sel_bits;
    end
  end
endmodule

// File: rtl/cfgb_cmd_engine.sv
module cfgb_cmd_engine
  import cfgb_pkg::*;
#(
  parameter int PADDR_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_wr,
  input  logic               cmd_go,
  input  logic               cmd_rd,
  input  logic [PADDR_W-1:0] cmd_addr,
  input  logic [PDATA_W-1:0] cmd_data,
  input  logic               prt_rdy,
  input  logic [PDATA_W-1:0] prt_rdata,
  output logic               prt_en,
  output logic               prt_we,
  output logic [PADDR_W-1:0] prt_addr,
  output logic [PDATA_W-1:0] prt_wdata,
  output logic               busy,
  output logic [PDATA_W-1:0] rd_data
);
  logic launch;
  logic finish;

  // a command is only accepted while nothing is outstanding
  assign launch = cmd_wr & cmd_go & ~busy;
  assign finish = busy & prt_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      prt_en    <= 1'b0;
      prt_we    <= 1'b0;
      prt_addr  <= '0;
      prt_wdata <= '0;
      busy      <= 1'b0;
      rd_data   <= '0;
    end else begin
      prt_en <= launch;
      if (launch) begin
        busy      <= 1'b1;
        prt_we    <= ~cmd_rd;
        prt_addr  <= cmd_addr;
        prt_wdata <= cmd_data;
      end else if (finish) begin
        busy <= 1'b0;
        if (!prt_we) rd_data <= prt_rdata;
      end
    end
  end
endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
  import cfgb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PADDR_W = 7,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_wr_en,
  input  logic               hst_rd_en,
  input  logic [ADDR_W-1:0]  hst_addr,
  input  logic [31:0]        hst_wdata,
  output logic [31:0]        hst_rdata,
  output logic               prt_en,
  output logic               prt_we,
  output logic [PADDR_W-1:0] prt_addr,
  output logic [PDATA_W-1:0] prt_wdata,
  input  logic               prt_rdy,
  input  logic [PDATA_W-1:0] prt_rdata,
  output logic               ctl_enable,
  output logic               ctl_release,
  output logic [SEL_W-1:0]   src_sel
);
  regsel_e             rsel;
  logic                busy_w;
  logic [PDATA_W-1:0]  rd_data_w;
  logic                unused_wbits;

  assign rsel         = decode_ofs(32'(hst_addr));
  assign unused_wbits = ^hst_wdata;

  cfgb_ctrl_regs #(.SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (hst_wr_en && rsel == RS_CTRL),
    .wr_sel     (hst_wr_en && rsel == RS_SEL),
    .ctrl_bits  (hst_wdata[1:0]),
    .sel_bits   (hst_wdata[SEL_W-1:0]),
    .ctl_enable (ctl_enable),
    .ctl_release(ctl_release),
    .src_sel    (src_sel)
  );

  cfgb_cmd_engine #(.PADDR_W(PADDR_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (hst_wr_en && rsel == RS_CMD),
    .cmd_go   (hst_wdata[CMD_GO_BIT]),
    .cmd_rd   (hst_wdata[CMD_RD_BIT]),
    .cmd_addr (hst_wdata[CMD_ADDR_LSB +: PADDR_W]),
    .cmd_data (hst_wdata[PDATA_W-1:0]),
    .prt_rdy  (prt_rdy),
    .prt_rdata(prt_rdata),
    .prt_en   (prt_en),
    .prt_we   (prt_we),
    .prt_addr (prt_addr),
    .prt_wdata(prt_wdata),
    .busy     (busy_w),
    .rd_data  (rd_data_w)
  );

  // registered readback, one cycle after the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_rd_en) begin
      case (rsel)
        RS_CTRL: hst_rdata <= {30'd0, ctl_release, ctl_enable};
        RS_SEL:  hst_rdata <= 32'(src_sel);
        RS_STAT: hst_rdata <= {15'd0, busy_w, rd_data_w};
        default: hst_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk
  import cfgb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PADDR_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               hst_wr_en,
  input logic [ADDR_W-1:0]  hst_addr,
  input logic               hst_wdata_b0,
  input logic               prt_en,
  input logic               prt_rdy,
  input logic               prt_we,
  input logic [PADDR_W-1:0] prt_addr,
  input logic [PDATA_W-1:0] prt_wdata,
  input logic               busy,
  input logic [PDATA_W-1:0] rd_data,
  input logic               ctl_enable
);
  assert_en_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    prt_en |=> !prt_en);

  assert_en_with_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> prt_en);

  assert_en_implies_busy_R4: assert property (@(posedge clk) disable iff (rst)
    prt_en |-> busy);

  assert_busy_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && prt_rdy) |=> !busy);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !prt_rdy) |=> busy);

  assert_port_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !prt_en) |-> ($stable(prt_addr) && $stable(prt_wdata) && $stable(prt_we)));

  assert_rd_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && prt_rdy) |=> $stable(rd_data));

  assert_ctl_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (hst_wr_en && hst_addr == ADDR_W'(OFS_CTRL)) |=> (ctl_enable == $past(hst_wdata_b0)));
endmodule

bind cfgport_bridge cfgport_bridge_chk #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .hst_wr_en   (hst_wr_en),
  .hst_addr    (hst_addr),
  .hst_wdata_b0(hst_wdata[0]),
  .prt_en      (prt_en),
  .prt_rdy     (prt_rdy),
  .prt_we      (prt_we),
  .prt_addr    (prt_addr),
  .prt_wdata   (prt_wdata),
  .busy        (busy_w),
  .rd_data     (rd_data_w),
  .ctl_enable  (ctl_enable)
);

// File: tb/cfgport_bridge_tb_top.sv
module cfgport_bridge_tb_top;
  localparam int ADDR_W = 8, PADDR_W = 7, SEL_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hst_wr_en = 1'b0, hst_rd_en = 1'b0;
  logic [ADDR_W-1:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic prt_en, prt_we;
  logic [PADDR_W-1:0] prt_addr;
  logic [15:0] prt_wdata;
  logic prt_rdy = 1'b0;
  logic [15:0] prt_rdata = '0;
  logic ctl_enable, ctl_release;
  logic [SEL_W-1:0] src_sel;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfgport_bridge #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst(rst), .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .prt_en(prt_en), .prt_we(prt_we), .prt_addr(prt_addr), .prt_wdata(prt_wdata),
    .prt_rdy(prt_rdy), .prt_rdata(prt_rdata), .ctl_enable(ctl_enable),
    .ctl_release(ctl_release), .src_sel(src_sel));

  // reference model state
  logic m_en, m_we, m_busy, m_cen, m_crel;
  logic [PADDR_W-1:0] m_addr;
  logic [15:0] m_wd, m_rd;
  logic [SEL_W-1:0] m_sel;
  logic [31:0] m_rdata;

  // synthesizer port model
  logic [15:0] pmem [128];
  int p_lat = 1, p_cnt = 0;
  bit p_pend = 0, p_stray = 0;
  logic [PADDR_W-1:0] p_addr;
  int p_writes = 0;

  function automatic logic [15:0] mem_init(int i);
    return 16'(i * 273) ^ 16'h0F00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic launch;
    if (rst) begin
      m_en = 0; m_we = 0; m_busy = 0; m_cen = 0; m_crel = 0;
      m_addr = '0; m_wd = '0; m_rd = '0; m_sel = '0; m_rdata = '0;
      return;
    end
    if (hst_rd_en) begin
      if (hst_addr == 8'h40)      m_rdata = {30'd0, m_crel, m_cen};
      else if (hst_addr == 8'h44) m_rdata = 32'(m_sel);
      else if (hst_addr == 8'h74) m_rdata = {15'd0, m_busy, m_rd};
      else                        m_rdata = 0;
    end
    launch = hst_wr_en && hst_addr == 8'h70 && hst_wdata[29] && !m_busy;
    if (launch) begin
      m_busy = 1; m_we = !hst_wdata[28];
      m_addr = hst_wdata[16 +: PADDR_W]; m_wd = hst_wdata[15:0];
    end else if (m_busy && prt_rdy) begin
      m_busy = 0;
      if (!m_we) m_rd = prt_rdata;
    end
    m_en = launch;
    if (hst_wr_en && hst_addr == 8'h40) begin m_cen = hst_wdata[0]; m_crel = hst_wdata[1]; end
    if (hst_wr_en && hst_addr == 8'h44) m_sel = hst_wdata[SEL_W-1:0];
  endtask

  task automatic port_update();
    prt_rdy = 0;
    if (p_pend) begin
      p_cnt--;
      if (p_cnt == 0) begin
        prt_rdy = 1; prt_rdata = pmem[p_addr]; p_pend = 0;
      end
    end
    if (prt_en) begin
      p_pend = 1; p_cnt = p_lat; p_addr = prt_addr;
      if (prt_we) begin pmem[prt_addr] = prt_wdata; p_writes++; end
    end
    if (p_stray) begin prt_rdy = 1; prt_rdata = 16'hAAAA; p_stray = 0; end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(prt_en == m_en, "R4 prt_en", 32'(prt_en), 32'(m_en));
    chk(prt_we == m_we, "R5 prt_we", 32'(prt_we), 32'(m_we));
    chk(prt_addr == m_addr, "R4 prt_addr", 32'(prt_addr), 32'(m_addr));
    chk(prt_wdata == m_wd, "R4 prt_wdata", 32'(prt_wdata), 32'(m_wd));
    chk(ctl_enable == m_cen && ctl_release == m_crel, "R2 ctl", {ctl_release, ctl_enable}, {m_crel, m_cen});
    chk(src_sel == m_sel, "R3 src_sel", 32'(src_sel), 32'(m_sel));
    chk(hst_rdata == m_rdata, "R10 hst_rdata", hst_rdata, m_rdata);
    port_update();
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    hst_wr_en = 1; hst_addr = a; hst_wdata = d;
    step();
    hst_wr_en = 0; hst_wdata = '0;
  endtask

  task automatic host_read(input logic [7:0] a);
    hst_rd_en = 1; hst_addr = a;
    step();
    hst_rd_en = 0;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    host_read(a);
    chk(hst_rdata == exp, tag, hst_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      host_read(8'h74);
      if (!hst_rdata[16]) break;
    end
    chk(!hst_rdata[16], "R6 busy clears", hst_rdata, 32'h0);
  endtask

  function automatic logic [31:0] cmd(bit go, bit rd, int a, logic [15:0] d);
    return (32'(go) << 29) | (32'(rd) << 28) | (32'(a) << 16) | 32'(d);
  endfunction

  initial begin
    int w0;
    for (int i = 0; i < 128; i++) pmem[i] = mem_init(i);
    repeat (3) step();
    rst = 0;
    // R1 / R10 reset state
    chk(prt_en == 0 && ctl_enable == 0 && ctl_release == 0 && src_sel == 0, "R1 outputs", 32'(prt_en), 0);
    read_chk(8'h74, 32'h0, "R1 status");
    read_chk(8'h40, 32'h0, "R1 ctrl");
    read_chk(8'h44, 32'h0, "R1 sel");
    // R2 control bits
    host_write(8'h40, 32'hFFFF_FFFF);
    chk(ctl_enable && ctl_release, "R2 both set", {ctl_release, ctl_enable}, 3);
    read_chk(8'h40, 32'h3, "R2 readback");
    host_write(8'h40, 32'h2);
    read_chk(8'h40, 32'h2, "R2 release only");
    // R3 select
    host_write(8'h44, 32'h2);
    read_chk(8'h44, 32'h2, "R3 readback");
    host_write(8'h44, 32'hFFFF_FFFD);
    read_chk(8'h44, 32'h1, "R3 low bits");
    // R4 R5 port write
    p_lat = 3;
    host_write(8'h70, cmd(1, 0, 5, 16'hBEEF));
    chk(prt_en && prt_we && prt_addr == 5 && prt_wdata == 16'hBEEF, "R4 launch", {prt_en, prt_we, 7'd0, prt_addr, prt_wdata}, 32'hBEEF);
    step();
    chk(!prt_en, "R4 single pulse", 32'(prt_en), 0);
    read_chk(8'h74, 32'h0001_0000, "R10 busy bit");
    wait_idle();
    chk(pmem[5] == 16'hBEEF, "R4 port stored", 32'(pmem[5]), 32'hBEEF);
    read_chk(8'h74, 32'h0, "R7 write leaves rd field");
    // R7 port read
    p_lat = 2;
    host_write(8'h70, cmd(1, 1, 5, 16'h1234));
    chk(prt_en && !prt_we, "R5 read dir", 32'(prt_we), 0);
    wait_idle();
    read_chk(8'h74, 32'h0000_BEEF, "R7 read data");
    // R8 command while busy
    p_lat = 4;
    w0 = p_writes;
    host_write(8'h70, cmd(1, 1, 9, 16'h0));
    host_write(8'h70, cmd(1, 0, 3, 16'h1234));
    chk(!prt_en && prt_addr == 9 && !prt_we, "R8 ignored", 32'(prt_addr), 9);
    wait_idle();
    chk(p_writes == w0, "R8 no port write", p_writes, w0);
    read_chk(8'h74, 32'(mem_init(9)), "R7 read addr 9");
    p_lat = 1;
    host_write(8'h70, cmd(1, 1, 3, 16'h0));
    wait_idle();
    read_chk(8'h74, 32'(mem_init(3)), "R8 addr 3 unchanged");
    // R9 no go bit
    host_write(8'h70, cmd(0, 0, 5, 16'h5555));
    chk(!prt_en, "R9 no launch", 32'(prt_en), 0);
    read_chk(8'h74, 32'(mem_init(3)), "R9 still idle");
    // R6 stray ready while idle
    p_stray = 1;
    step();
    step();
    read_chk(8'h74, 32'(mem_init(3)), "R6 stray ready ignored");
    // R11 zero reads
    read_chk(8'h70, 32'h0, "R11 cmd reads zero");
    read_chk(8'h10, 32'h0, "R11 unmapped");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule